// File: doc/BRIEF.md
# Interrupt Aggregation Wrapper with End-of-Interrupt Re-arm

This block sits beside a USB controller core and funnels its many interrupt lines into one request line for a processor. Per-endpoint transmit events, per-endpoint receive events, eight core-level events and a bus-power-drive change event are packed into one 32-bit pending register. Each event is a single-cycle pulse that latches its pending bit. Software can force pending bits or remove them through separate write-one alias offsets. An enable register, with its own write-one set and clear aliases, selects which pending bits may raise the request. A read-only view returns the pending bits that are also enabled.

The request output behaves as a one-shot. Once it rises it stays high until software writes the end-of-interrupt offset, even if the pending bits are cleared in the meantime. The write drops the line for one cycle. If enabled bits are still pending, the line then rises again, so the processor sees a fresh edge for work that is still outstanding.

Access goes through a simple register port with separate read and write strobes. Read data is combinational and is valid in the same cycle as the read strobe.

Top module: `irqg_top`

## Requirements
- R1: After a synchronous active-low reset the pending and enable registers read zero and `irq_o` is low.
- R2: Event packing: `tx_evt_i[i]` sets bit i (bits 4:0). `rx_evt_i[j]`, for endpoint j+1, sets bit 9+j (bits 12:9). `core_evt_i[k]` sets bit 16+k (bits 23:16). `vbus_evt_i` sets bit 24. All other bits always read 0.
- R3: A one-cycle event pulse latches its pending bit in the cycle of the pulse. The bit stays set after the pulse ends until it is cleared.
- R4: A write to offset 0x24 ORs the written ones into the pending register. Only the bits that R2 defines are affected.
- R5: A write to offset 0x28 clears the pending bits written as one and leaves the others unchanged.
- R6: If an event pulse and a 0x28 clear hit the same bit in one cycle, the bit ends up set.
- R7: A write to 0x30 sets the enable bits written as one, and a write to 0x34 clears them. The enable register reads at 0x2C.
- R8: Offset 0x38 reads the pending register AND the enable register. Offset 0x20 reads the pending register.
- R9: `irq_o` rises one cycle after an enabled pending bit exists, provided it is not already high. Once high it stays high until an end-of-interrupt write, even if no enabled bit remains pending.
- R10: A write to 0x3C drives `irq_o` low in the next cycle. If an enabled bit is still pending, `irq_o` rises again one cycle later.
- R11: Writes to the read-only offsets 0x20, 0x2C and 0x38 change no register.
- R12: Reads of the alias offsets, of the end-of-interrupt offset and of unmapped offsets return 0. `rdata_o` is 0 when `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the read cycle |
| tx_evt_i | input | 5 | Transmit endpoint event pulses (endpoints 0 to 4) |
| rx_evt_i | input | 4 | Receive endpoint event pulses (endpoints 1 to 4) |
| core_evt_i | input | 8 | Core-level event pulses |
| vbus_evt_i | input | 1 | Bus-power-drive change event pulse |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A corrupted pending or enable bit becomes visible at the next read of 0x20, 0x2C or 0x38. It also shows on `irq_o` one cycle after it makes the enabled set non-empty. A stuck or lost one-shot state shows up as an `irq_o` that fails to drop in the cycle after an end-of-interrupt write, or that fails to rise again one cycle after that while work is still pending. Wrong packing or a lost set/clear priority shows at the first readback of the pending register after the event or write concerned.

// File: rtl/irqg_pkg.sv
// Shared constants for the interrupt aggregation wrapper.
// Assumes a 32-bit data path and byte offsets that fit in 8 bits.
package irqg_pkg;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 32;

    // Register offsets; software depends on these values.
    localparam logic [ADDR_W-1:0] OFF_PEND      = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_PEND_SET  = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_PEND_CLR  = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_ENA       = 8'h2C;
    localparam logic [ADDR_W-1:0] OFF_ENA_SET   = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_ENA_CLR   = 8'h34;
    localparam logic [ADDR_W-1:0] OFF_ACTIVE    = 8'h38;
    localparam logic [ADDR_W-1:0] OFF_EOI       = 8'h3C;

    // Field anchors: receive field is shifted by 8 with no endpoint-0 bit,
    // core field (plus bus-power event on top) starts at 16.
    localparam int unsigned RX_SHIFT   = 8;
    localparam int unsigned CORE_SHIFT = 16;

    // Contiguous mask of n ones starting at bit lsb.
    function automatic logic [DATA_W-1:0] field_mask(input int unsigned lsb,
                                                     input int unsigned n);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int unsigned b = 0; b < DATA_W; b++) begin
            if (b >= lsb && b < lsb + n) m[b] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/irqg_pack.sv
// Packs the event pulse inputs into the 32-bit pending-register layout.
// Assumes the field widths fit below their neighbours' anchors.
module irqg_pack #(
    parameter int unsigned TX_N   = 5,
    parameter int unsigned RX_N   = 4,
    parameter int unsigned CORE_N = 8
) (
    input  logic [TX_N-1:0]               tx_evt,
    input  logic [RX_N-1:0]               rx_evt,
    input  logic [CORE_N-1:0]             core_evt,
    input  logic                          vbus_evt,
    output logic [irqg_pkg::DATA_W-1:0]   vec
);
    import irqg_pkg::*;
    localparam int unsigned RX_LSB   = RX_SHIFT + 1;
    localparam int unsigned CORE_LSB = CORE_SHIFT;
    localparam int unsigned VBUS_BIT = CORE_LSB + CORE_N;

    // Place every event line at its fixed bit position.
    always_comb begin
        vec = '0;
        vec[0 +: TX_N]          = tx_evt;
        vec[RX_LSB +: RX_N]     = rx_evt;
        vec[CORE_LSB +: CORE_N] = core_evt;
        vec[VBUS_BIT]           = vbus_evt;
    end
endmodule

// File: rtl/irqg_bitreg.sv
// Per-bit set/clear register. Hardware set has priority over a software
// clear in the same cycle. Bits outside VALID are built as constant zero.
// Assumes set and clear vectors are single-cycle strobes.
module irqg_bitreg #(
    parameter int unsigned W = 32,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hw_set,
    input  logic [W-1:0] sw_set,
    input  logic [W-1:0] sw_clr,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (VALID[i]) begin : g_live
            logic b_q;
            // Latch: hardware event wins, then software set/clear.
            always_ff @(posedge clk) begin
                if (!rst_n) b_q <= 1'b0;
                else        b_q <= hw_set[i] | ((b_q | sw_set[i]) & ~sw_clr[i]);
            end
            assign q[i] = b_q;
        end else begin : g_dead
            assign q[i] = 1'b0;
        end
    end

    // R3: with no clear, no set bit is lost.
    a_r3_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr == '0) |=> ((q & $past(q)) == $past(q)));

    // R6: a hardware-set valid bit is set next cycle regardless of clear.
    a_r6_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q & $past(hw_set & VALID)) == $past(hw_set & VALID)));
endmodule

// File: rtl/irqg_eoi.sv
// One-shot request line: rises when enabled work is pending, holds until
// an end-of-interrupt strobe, then re-evaluates one cycle later.
// Assumes eoi is a single-cycle write strobe.
module irqg_eoi (
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic eoi,
    output logic irq
);
    logic irq_q;

    // Hold once raised; the EOI strobe is the only way down.
    always_ff @(posedge clk) begin
        if (!rst_n)   irq_q <= 1'b0;
        else if (eoi) irq_q <= 1'b0;
        else          irq_q <= irq_q | pending;
    end
    assign irq = irq_q;

    // R9: line stays high until EOI.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !eoi) |=> irq);
    // R9: pending work raises an idle line one cycle later.
    a_r9_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && pending && !eoi) |=> irq);
    // R10: EOI always drops the line in the next cycle.
    a_r10_drop: assert property (@(posedge clk) disable iff (!rst_n)
        eoi |=> !irq);
endmodule

// File: rtl/irqg_top.sv
// Interrupt aggregation wrapper: packs event pulses into a pending
// register, applies an enable register, and drives a one-shot request
// re-armed by an end-of-interrupt write. Read data is combinational.
// Assumes wr_en_i and rd_en_i are never high for more than the intended cycle.
module irqg_top #(
    parameter int unsigned TX_N   = 5,
    parameter int unsigned RX_N   = 4,
    parameter int unsigned CORE_N = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  logic                        rd_en_i,
    input  logic [irqg_pkg::ADDR_W-1:0] addr_i,
    input  logic [irqg_pkg::DATA_W-1:0] wdata_i,
    output logic [irqg_pkg::DATA_W-1:0] rdata_o,
    input  logic [TX_N-1:0]             tx_evt_i,
    input  logic [RX_N-1:0]             rx_evt_i,
    input  logic [CORE_N-1:0]           core_evt_i,
    input  logic                        vbus_evt_i,
    output logic                        irq_o
);
    import irqg_pkg::*;

    localparam logic [DATA_W-1:0] VALID =
        field_mask(0, TX_N) |
        field_mask(RX_SHIFT + 1, RX_N) |
        field_mask(CORE_SHIFT, CORE_N + 1);

    logic [DATA_W-1:0] evt_vec;
    logic [DATA_W-1:0] pend_q, ena_q, active;
    logic [DATA_W-1:0] pend_set, pend_clr, ena_set, ena_clr;
    logic              eoi_wr;

    irqg_pack #(.TX_N(TX_N), .RX_N(RX_N), .CORE_N(CORE_N)) u_pack (
        .tx_evt(tx_evt_i), .rx_evt(rx_evt_i), .core_evt(core_evt_i),
        .vbus_evt(vbus_evt_i), .vec(evt_vec)
    );

    // Decode write strobes into per-register set/clear vectors.
    always_comb begin
        pend_set = (wr_en_i && addr_i == OFF_PEND_SET) ? wdata_i : '0;
        pend_clr = (wr_en_i && addr_i == OFF_PEND_CLR) ? wdata_i : '0;
        ena_set  = (wr_en_i && addr_i == OFF_ENA_SET)  ? wdata_i : '0;
        ena_clr  = (wr_en_i && addr_i == OFF_ENA_CLR)  ? wdata_i : '0;
        eoi_wr   = wr_en_i && addr_i == OFF_EOI;
    end

    irqg_bitreg #(.W(DATA_W), .VALID(VALID)) u_pend (
        .clk(clk), .rst_n(rst_n), .hw_set(evt_vec),
        .sw_set(pend_set), .sw_clr(pend_clr), .q(pend_q)
    );

    irqg_bitreg #(.W(DATA_W), .VALID(VALID)) u_ena (
        .clk(clk), .rst_n(rst_n), .hw_set('0),
        .sw_set(ena_set), .sw_clr(ena_clr), .q(ena_q)
    );

    assign active = pend_q & ena_q;

    irqg_eoi u_eoi (
        .clk(clk), .rst_n(rst_n), .pending(|active),
        .eoi(eoi_wr), .irq(irq_o)
    );

    // Read mux: only the three readable offsets return data.
    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            case (addr_i)
                OFF_PEND:   rdata_o = pend_q;
                OFF_ENA:    rdata_o = ena_q;
                OFF_ACTIVE: rdata_o = active;
                default:    rdata_o = '0;
            endcase
        end
    end

    // R7: the enable register moves only on its set/clear aliases.
    a_r7_ena_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_set == '0 && ena_clr == '0) |=> $stable(ena_q));
endmodule

// File: tb/test_irqg_top.sv
module test_irqg_top;
    localparam int unsigned TX_N = 5, RX_N = 4, CORE_N = 8;
    localparam logic [31:0] VALID = 32'h0000_001F | (32'h0000_000F << 9) | (32'h0000_01FF << 16);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [TX_N-1:0]   tx_evt = '0;
    logic [RX_N-1:0]   rx_evt = '0;
    logic [CORE_N-1:0] core_evt = '0;
    logic        vbus_evt = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct { logic [7:0] a; logic [31:0] exp; string tag; } exp_t;
    exp_t sbq[$];

    always #5 clk = ~clk;

    irqg_top #(.TX_N(TX_N), .RX_N(RX_N), .CORE_N(CORE_N)) i_irqg_top (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .tx_evt_i(tx_evt), .rx_evt_i(rx_evt), .core_evt_i(core_evt),
        .vbus_evt_i(vbus_evt), .irq_o(irq)
    );

    // Monitor: pop the expected read and compare mid-cycle.
    always @(negedge clk) begin
        if (rd_en && sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            checks++;
            if (rdata !== e.exp) begin
                errors++;
                $display("FAIL %s: read 0x%02h got 0x%08h expected 0x%08h", e.tag, e.a, rdata, e.exp);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_t item;
        @(posedge clk); #1;
        item.a = a; item.exp = e; item.tag = tag;
        sbq.push_back(item);
        rd_en = 1'b1; addr = a;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [TX_N-1:0] t, input logic [RX_N-1:0] r,
                         input logic [CORE_N-1:0] c, input logic v);
        @(posedge clk); #1;
        tx_evt = t; rx_evt = r; core_evt = c; vbus_evt = v;
        @(posedge clk); #1;
        tx_evt = '0; rx_evt = '0; core_evt = '0; vbus_evt = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s: irq got %b expected %b", tag, irq, e);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(8'h20, 32'h0, "R1 pending");
        rd(8'h2C, 32'h0, "R1 enable");
        chk_irq(1'b0, "R1 irq");

        // R2/R3 packing and latching of one-cycle pulses
        pulse(5'b00001, 4'b0001, 8'h80, 1'b1);
        rd(8'h20, 32'h0180_0201, "R2 R3 packed pulses");
        chk_irq(1'b0, "R9 disabled no irq");

        // R7 enable set, R8 masked view
        wr(8'h30, 32'hFFFF_FFFF);
        rd(8'h2C, VALID, "R7 enable set");
        rd(8'h38, 32'h0180_0201, "R8 active view");
        chk_irq(1'b1, "R9 rise");

        // R9 hold after pending cleared
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h20, 32'h0, "R5 clear all");
        chk_irq(1'b1, "R9 hold without pending");

        // R10 EOI with nothing pending
        wr(8'h3C, 32'h0);
        chk_irq(1'b0, "R10 drop");
        chk_irq(1'b0, "R10 stays low idle");

        // R4 software set, then R10 re-assert
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h20, VALID, "R4 set alias");
        chk_irq(1'b1, "R9 rise on sw set");
        wr(8'h3C, 32'h0);
        chk_irq(1'b0, "R10 low one cycle");
        chk_irq(1'b1, "R10 re-assert");

        // R5 partial clear
        wr(8'h28, 32'h0000_FFFF);
        rd(8'h20, 32'h01FF_0000, "R5 partial clear");

        // R6 same-cycle hardware set and software clear on bit 2
        @(posedge clk); #1;
        tx_evt = 5'b00100; wr_en = 1'b1; addr = 8'h28; wdata = 32'h0000_0004;
        @(posedge clk); #1;
        tx_evt = '0; wr_en = 1'b0; wdata = '0;
        rd(8'h20, 32'h01FF_0004, "R6 hw wins");

        // R7 enable clear, R8 masked view
        wr(8'h34, 32'h00FF_0000);
        rd(8'h2C, 32'h0100_1E1F, "R7 enable clear");
        rd(8'h38, 32'h0100_0004, "R8 masked and");

        // R11 writes to read-only offsets
        wr(8'h20, 32'h0);
        wr(8'h2C, 32'h0);
        wr(8'h38, 32'h0);
        rd(8'h20, 32'h01FF_0004, "R11 pending untouched");
        rd(8'h2C, 32'h0100_1E1F, "R11 enable untouched");

        // R12 non-readable offsets
        rd(8'h24, 32'h0, "R12 alias reads zero");
        rd(8'h3C, 32'h0, "R12 eoi reads zero");
        rd(8'h10, 32'h0, "R12 unmapped");
        @(negedge clk);
        checks++;
        if (rdata !== 32'h0) begin
            errors++;
            $display("FAIL R12 idle rdata: got 0x%08h expected 0x00000000", rdata);
        end

        // R9 pending but disabled: no re-assert after EOI
        wr(8'h34, 32'hFFFF_FFFF);
        wr(8'h3C, 32'h0);
        chk_irq(1'b0, "R9 disabled after eoi");
        chk_irq(1'b0, "R9 disabled stays low");
        rd(8'h38, 32'h0, "R8 nothing enabled");

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule